// File: doc/BRIEF.md
# Tagged Operand Type Checker

This block checks the types of the two operands of an ALU operation while the arithmetic runs alongside it. Each operand is a 33-bit word: bit 32 is the boxed flag, bits 31:26 carry a 6-bit type tag, and bits 25:0 hold a word pointer or an immediate payload. The boxed flag and the low tag bits of both operands are joined with a 2-bit check-operation code from the instruction and a 2-bit policy mode, and the resulting key selects one bit in a writable permission table. A zero bit means the operation is not allowed, and the block raises a trap unless checking is off for that operation or traps are masked. The same stage also produces the boxed flag of the ALU result from a 2-bit control field.

The type rules are not wired in. They live in the permission table, and software fills that table by sending operand pairs through the normal operand path with a write flag set on each beat. Every possible key is therefore loaded through the same path that checks it. The policy mode sits in a small register, so software can switch to a different rule set, for example while the collector is running. After reset every table bit is zero, so every checked operation traps until the table has been loaded.

Operands enter as a valid/ready stream into one register stage, and the result leaves it as a valid/ready stream. A beat is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the stage is empty or its result is being taken in the same cycle. A result that is not taken stays unchanged until `out_ready` rises. The mode write port and the trap mask are plain control pins.

Top module: `tchk_top`

## Requirements
- R1: While reset is low and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1. Reset clears the mode register to 0 and every permission bit to 0.
- R2: A beat is taken in each cycle where `in_valid` and `in_ready` are both high, and its result is shown with `out_valid` high from the next cycle on. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all result outputs stay the same.
- R3: The table index of a beat is, from most to least significant: the left boxed bit (bit 32), the low LUT_TAG_W bits of the left tag (starting at bit 26), the right boxed bit, the low LUT_TAG_W bits of the right tag, `in_op`, and the mode. The pointer bits 25:0 and the upper tag bits do not change the result.
- R4: `mode_we` loads `mode_wdata` into the mode register at the clock edge. A beat taken at that same edge uses the mode value held before the edge.
- R5: A beat with `in_wr` high writes `in_wr_bit` into the table at its index in the cycle where it leaves the stage (`out_valid && out_ready`). `out_ok` for that beat shows the table content before the write.
- R6: `out_ok` is the table bit at the held beat's index. `out_trap` is high exactly when `out_valid`, the beat's `in_chk_en`, `!out_ok`, `!trap_mask` and not a write beat are all true.
- R7: A write beat never raises `out_trap`, and `trap_mask` high forces `out_trap` low in the same cycle.
- R8: `out_boxed` follows the beat's `in_boxctl`: 0 copies the left boxed bit, 1 gives the inverse of the left boxed bit, 2 gives 0, and 3 gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Stage can take a beat |
| in_left | input | 33 | Left operand word |
| in_right | input | 33 | Right operand word |
| in_op | input | 2 | Check-operation code |
| in_chk_en | input | 1 | Type check applies to this beat |
| in_boxctl | input | 2 | Result boxed-flag control |
| in_wr | input | 1 | Beat programs the permission table |
| in_wr_bit | input | 1 | Permission value to program |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | New policy mode |
| trap_mask | input | 1 | Global trap mask |
| out_valid | output | 1 | Result held in stage |
| out_ready | input | 1 | Consumer takes the result |
| out_ok | output | 1 | Permission bit for the held beat |
| out_boxed | output | 1 | Boxed flag of the ALU result |
| out_trap | output | 1 | Type-check trap |

## Verification
A corrupted table bit does not show until a beat reads that exact index. From then on it appears on `out_ok` and usually on `out_trap`, so the bench programs every index with random values and reads each one back under every mode. A wrong mode capture or a swapped key field moves the lookup to another index, and `out_ok` then differs within a cycle of the beat being taken, for about half of all keys. A handshake fault, such as a result that changes while it is stalled or a wrong `in_ready`, shows on the next clock. The bench therefore applies random back-pressure and compares every output on every cycle against a behavioural model.

// File: rtl/tchk_pkg.sv
package tchk_pkg;
  localparam int WORD_W  = 33;
  localparam int BOX_BIT = 32;
  localparam int TAG_LSB = 26;
  localparam int TAG_W   = 6;

  typedef enum logic [1:0] {
    BOX_COPY = 2'b00,
    BOX_INV  = 2'b01,
    BOX_CLR  = 2'b10,
    BOX_SET  = 2'b11
  } boxctl_e;
endpackage

// File: rtl/tchk_keyform.sv
module tchk_keyform
  import tchk_pkg::*;
#(
  parameter int LUT_TAG_W = 2,
  parameter int OP_W      = 2,
  parameter int MODE_W    = 2,
  localparam int KEY_W    = 2 * (1 + LUT_TAG_W) + OP_W + MODE_W
) (
  input  logic [WORD_W-1:0] left,
  input  logic [WORD_W-1:0] right,
  input  logic [OP_W-1:0]   op,
  input  logic [MODE_W-1:0] mode,
  output logic [KEY_W-1:0]  key
);
  logic [LUT_TAG_W-1:0] ltag, rtag;

  assign ltag = left[TAG_LSB +: LUT_TAG_W];
  assign rtag = right[TAG_LSB +: LUT_TAG_W];
  assign key  = {left[BOX_BIT], ltag, right[BOX_BIT], rtag, op, mode};
endmodule

// File: rtl/tchk_stage.sv
module tchk_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end

  assert_take_shows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  assert_stall_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/tchk_perm_mem.sv
module tchk_perm_mem #(
  parameter int KEY_W = 10,
  localparam int DEPTH = 1 << KEY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] rd_key,
  output logic             rd_bit,
  input  logic             we,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             wr_bit
);
  logic [DEPTH-1:0] bits_q;

  assign rd_bit = bits_q[rd_key];

  always_ff @(posedge clk) begin
    if (!rst_n) bits_q <= '0;
    else if (we) bits_q[wr_key] <= wr_bit;
  end

  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (bits_q[$past(wr_key)] == $past(wr_bit)));
endmodule

// File: rtl/tchk_boxsel.sv
module tchk_boxsel
  import tchk_pkg::*;
(
  input  logic    left_box,
  input  boxctl_e ctl,
  output logic    res_box
);
  always_comb begin
    unique case (ctl)
      BOX_COPY: res_box = left_box;
      BOX_INV:  res_box = !left_box;
      BOX_CLR:  res_box = 1'b0;
      default:  res_box = 1'b1;
    endcase
  end
endmodule

// File: rtl/tchk_top.sv
module tchk_top
  import tchk_pkg::*;
#(
  parameter int LUT_TAG_W = 2,
  parameter int OP_W      = 2,
  parameter int MODE_W    = 2,
  localparam int KEY_W    = 2 * (1 + LUT_TAG_W) + OP_W + MODE_W,
  localparam int DATA_W   = KEY_W + 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_left,
  input  logic [WORD_W-1:0] in_right,
  input  logic [OP_W-1:0]   in_op,
  input  logic              in_chk_en,
  input  logic [1:0]        in_boxctl,
  input  logic              in_wr,
  input  logic              in_wr_bit,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              trap_mask,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_ok,
  output logic              out_boxed,
  output logic              out_trap
);
  logic [MODE_W-1:0] mode_q;
  logic [KEY_W-1:0]  in_key, q_key;
  logic [DATA_W-1:0] st_in, st_out;
  logic              q_chk, q_boxl, q_wr, q_wbit;
  logic [1:0]        q_bc;
  logic              perm_bit, mem_we;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else if (mode_we) mode_q <= mode_wdata;
  end

  tchk_keyform #(.LUT_TAG_W(LUT_TAG_W), .OP_W(OP_W), .MODE_W(MODE_W)) u_key (
    .left(in_left), .right(in_right), .op(in_op), .mode(mode_q), .key(in_key));

  assign st_in = {in_key, in_chk_en, in_left[BOX_BIT], in_boxctl, in_wr, in_wr_bit};

  tchk_stage #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(st_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(st_out));

  assign {q_key, q_chk, q_boxl, q_bc, q_wr, q_wbit} = st_out;
  assign mem_we = out_valid && out_ready && q_wr;

  tchk_perm_mem #(.KEY_W(KEY_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .rd_key(q_key), .rd_bit(perm_bit),
    .we(mem_we), .wr_key(q_key), .wr_bit(q_wbit));

  tchk_boxsel u_box (.left_box(q_boxl), .ctl(boxctl_e'(q_bc)), .res_box(out_boxed));

  assign out_ok   = perm_bit;
  assign out_trap = out_valid && q_chk && !perm_bit && !trap_mask && !q_wr;

  assert_mode_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (mode_q == $past(mode_wdata)));
  assert_trap_needs_deny_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_trap |-> (out_valid && !out_ok));
  assert_trap_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_trap |-> (!trap_mask && !q_wr));
  assert_force_boxed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_bc == 2'b11) |-> out_boxed);
endmodule

// File: tb/sim_tchk_top.sv
`timescale 1ns/1ps
module sim_tchk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 0, in_chk_en = 0, in_wr = 0, in_wr_bit = 0;
  logic [32:0] in_left = '0, in_right = '0;
  logic [1:0]  in_op = '0, in_boxctl = '0, mode_wdata = '0;
  logic        mode_we = 0, trap_mask = 0, out_ready = 0;
  logic        in_ready, out_valid, out_ok, out_boxed, out_trap;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tchk_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .in_op(in_op), .in_chk_en(in_chk_en),
    .in_boxctl(in_boxctl), .in_wr(in_wr), .in_wr_bit(in_wr_bit),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .trap_mask(trap_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_ok(out_ok),
    .out_boxed(out_boxed), .out_trap(out_trap));

  // behavioural reference
  bit sh [0:1023];
  bit m_valid, m_chk, m_boxl, m_wr, m_wbit, m_acc;
  int m_key, m_mode, m_bc;

  function automatic int bkey(logic [32:0] l, logic [32:0] r, logic [1:0] op, int md);
    int k;
    k = l[32];
    k = k * 4 + l[27:26];
    k = k * 2 + r[32];
    k = k * 4 + r[27:26];
    k = k * 4 + op;
    k = k * 4 + md;
    return k;
  endfunction

  always @(posedge clk) begin
    bit acc, leave;
    if (!rst_n) begin
      m_valid = 0; m_mode = 0; m_acc = 0;
      foreach (sh[i]) sh[i] = 0;
    end else begin
      leave = m_valid && out_ready;
      acc = in_valid && (!m_valid || out_ready);
      if (leave && m_wr) sh[m_key] = m_wbit;
      if (acc) begin
        m_key = bkey(in_left, in_right, in_op, m_mode);
        m_chk = in_chk_en; m_boxl = in_left[32]; m_bc = in_boxctl;
        m_wr = in_wr; m_wbit = in_wr_bit; m_valid = 1;
      end else if (leave) m_valid = 0;
      if (mode_we) m_mode = mode_wdata;
      m_acc = acc;
    end
  end

  task automatic check(input string rq, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0b exp=%0b at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit eb, et;
    check("R2 in_ready", in_ready, !m_valid || out_ready);
    check("R2 out_valid", out_valid, m_valid);
    if (m_valid) begin
      check("R3 R4 R5 R6 out_ok", out_ok, sh[m_key]);
      case (m_bc)
        0: eb = m_boxl;
        1: eb = !m_boxl;
        2: eb = 0;
        default: eb = 1;
      endcase
      check("R8 out_boxed", out_boxed, eb);
      et = m_chk && !sh[m_key] && !trap_mask && !m_wr;
      check("R6 R7 out_trap", out_trap, et);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  // operand words for an 8-bit inner key, random filler in the don't-care bits
  task automatic set_opnds(input int j);
    in_left  = {j[7], 4'($urandom), j[6:5], 26'($urandom)};
    in_right = {j[4], 4'($urandom), j[3:2], 26'($urandom)};
    in_op    = j[1:0];
  endtask

  task automatic set_mode(input int md);
    in_valid = 0; mode_we = 1; mode_wdata = md[1:0];
    tick();
    mode_we = 0;
  endtask

  // offer one beat until taken
  task automatic send(input int j);
    set_opnds(j);
    in_valid = 1;
    do begin
      out_ready = ($urandom % 4) != 0;
      in_boxctl = 2'($urandom);
      trap_mask = ($urandom % 8) == 0;
      tick();
    end while (!m_acc);
    in_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", out_valid, 1'b0);
    check("R1 in_ready in reset", in_ready, 1'b1);
    rst_n = 1;
    @(negedge clk);
    check("R1 out_valid after reset", out_valid, 1'b0);
    check("R1 in_ready after reset", in_ready, 1'b1);

    // unprogrammed table: every checked beat is denied
    in_chk_en = 1; in_wr = 0;
    for (int j = 0; j < 16; j++) begin
      send(j * 13);
      check("R1 table clear", out_ok, 1'b0);
    end
    out_ready = 1; tick();

    // program every index under each mode through the operand path
    in_wr = 1;
    for (int md = 0; md < 4; md++) begin
      set_mode(md);
      for (int j = 0; j < 256; j++) begin
        in_wr_bit = $urandom % 2;
        send(j);
      end
    end
    out_ready = 1; tick();

    // read back everything
    in_wr = 0;
    for (int md = 3; md >= 0; md--) begin
      set_mode(md);
      for (int j = 0; j < 256; j++) begin
        in_chk_en = $urandom % 2;
        send(255 - j);
      end
    end

    // free-running random traffic with mode changes on the fly
    for (int n = 0; n < 4000; n++) begin
      in_valid = $urandom % 2;
      set_opnds($urandom % 256);
      in_chk_en = $urandom % 2;
      in_wr = ($urandom % 10) == 0;
      in_wr_bit = $urandom % 2;
      in_boxctl = 2'($urandom);
      mode_we = ($urandom % 6) == 0;
      mode_wdata = 2'($urandom);
      trap_mask = ($urandom % 5) == 0;
      out_ready = ($urandom % 3) != 0;
      tick();
    end
    mode_we = 0; in_valid = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL R2 watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule